// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block owns the four enable lines of a flat panel: the logic supply rail, the panel data signals, the backlight bias and the final panel-on control. A power-up request turns the lines on one at a time, from supply to panel-on. A power-down request turns them off one at a time in the mirrored order. After every single change the block waits a programmable number of video frames before it takes the next step. It counts the frames on a vertical-sync input that a timing generator elsewhere drives.

Each counted frame has two phases. First the block waits for vsync to be seen low, then for it to be seen high. Each phase has its own cycle limit, so a timing generator that has stopped cannot hang the sequence. A request that arrives while a sequence is running is held only if it points the other way. The block then turns around from whatever rail state it has reached, once the current settle wait ends. A one-cycle done pulse marks the return to idle.

Top module: `panel_pwr_seq`

## Requirements
- R1: After synchronous reset, all enables (`rail_en`) are low, and `busy` and `done` are low.
- R2: Power-up sets `rail_en` bits in ascending order: bit 0 supply, bit 1 data signals, bit 2 bias, bit 3 panel-on. The first bit rises at the clock edge that samples the request in idle.
- R3: Power-down clears the bits in descending order, from bit 3 down to bit 0.
- R4: Every change of `rail_en` flips exactly one bit, and all other bits hold their values.
- R5: Between one step and the next, the block counts SETTLE_FRAMES frames. A frame is a wait for vsync low, then a wait for vsync high, so SETTLE_FRAMES vsync rising edges fall between consecutive changes.
- R6: Each phase of a frame wait ends after PHASE_TIMEOUT cycles even when vsync never changes. With vsync stuck, the gap between steps lies between SETTLE_FRAMES*PHASE_TIMEOUT and SETTLE_FRAMES*(PHASE_TIMEOUT+1)+6 cycles.
- R7: `busy` is high from the first step until the settle wait after the last step ends. At that point `done` pulses high for exactly one cycle, and `busy` falls.
- R8: In idle, a request for the state already held (up while all four enables are set, down while none is set) pulses `done` at the next edge, leaves `rail_en` unchanged and keeps `busy` low.
- R9: During a sequence, a request in the opposite direction is latched. When the current settle wait ends, the sequence continues in the new direction from the current bits. A request in the same direction is ignored.
- R10: If both requests are high together in idle, power-up takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Power-up request |
| down_req | input | 1 | Power-down request |
| vsync | input | 1 | Vertical sync, active high, synchronous to clk |
| rail_en | output | RAILS | Enables: bit 0 supply, 1 signals, 2 bias, 3 panel-on |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The bench builds the block with SETTLE_FRAMES=2 and PHASE_TIMEOUT=16. With these values a full four-step sequence takes well under a hundred cycles, so the bench can sweep every reversal point of the power-up sequence (after one, two, three and four steps) as well as a down-to-up turnaround. The short limit lets the bench hold vsync stuck low and stuck high and measure the time-out gaps directly. A toggling vsync with a 10-cycle period stays inside the limit, so the bench can count rising edges exactly between steps.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/pps_frame_waiter.sv
module pps_frame_waiter
  import pps_pkg::*;
#(
  parameter int FRAMES  = 4,
  parameter int TIMEOUT = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic vsync,
  output logic fin
);
  localparam int FW = $clog2(FRAMES) + 1;
  localparam int TW = $clog2(TIMEOUT) + 1;
  localparam logic [FW-1:0] FLAST = FW'(FRAMES - 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  phase_e        ph;
  logic [FW-1:0] fcnt;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      fcnt <= '0;
      tcnt <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph   <= PH_LOW;
            fcnt <= '0;
            tcnt <= '0;
          end
        end
        PH_LOW: begin
          // leave when vsync is inactive, or give up after the limit
          if (!vsync || tcnt == TLAST) begin
            ph   <= PH_HIGH;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (vsync || tcnt == TLAST) begin
            tcnt <= '0;
            if (fcnt == FLAST) begin
              ph  <= PH_IDLE;
              fin <= 1'b1;
            end else begin
              fcnt <= fcnt + 1'b1;
              ph   <= PH_LOW;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pps_step_ctrl.sv
module pps_step_ctrl
  import pps_pkg::*;
#(
  parameter int RAILS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_req,
  input  logic             down_req,
  input  logic             fin,
  output logic [RAILS-1:0] rails,
  output logic             busy,
  output logic             done,
  output logic             start
);
  dir_e dir;
  logic pend;
  logic rev_req;
  logic rev_now;
  dir_e go_dir;
  logic go_complete;
  logic [RAILS-1:0] go_next;

  // thermometer stepping: the next rail above, or the top rail removed
  function automatic logic [RAILS-1:0] step_rails(input logic [RAILS-1:0] r, input dir_e d);
    if (d == DIR_UP) step_rails = {r[RAILS-2:0], 1'b1};
    else             step_rails = {1'b0, r[RAILS-1:1]};
  endfunction

  function automatic logic at_target(input logic [RAILS-1:0] r, input dir_e d);
    if (d == DIR_UP) at_target = &r;
    else             at_target = ~|r;
  endfunction

  always_comb begin
    rev_req     = (dir == DIR_UP) ? down_req : up_req;
    rev_now     = pend | rev_req;
    go_dir      = rev_now ? ((dir == DIR_UP) ? DIR_DOWN : DIR_UP) : dir;
    go_complete = at_target(rails, go_dir);
    go_next     = step_rails(rails, go_dir);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rails <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      start <= 1'b0;
      dir   <= DIR_UP;
      pend  <= 1'b0;
    end else begin
      done  <= 1'b0;
      start <= 1'b0;
      if (!busy) begin
        pend <= 1'b0;
        if (up_req) begin
          if (at_target(rails, DIR_UP)) begin
            done <= 1'b1;
          end else begin
            dir   <= DIR_UP;
            rails <= step_rails(rails, DIR_UP);
            start <= 1'b1;
            busy  <= 1'b1;
          end
        end else if (down_req) begin
          if (at_target(rails, DIR_DOWN)) begin
            done <= 1'b1;
          end else begin
            dir   <= DIR_DOWN;
            rails <= step_rails(rails, DIR_DOWN);
            start <= 1'b1;
            busy  <= 1'b1;
          end
        end
      end else if (fin) begin
        pend <= 1'b0;
        dir  <= go_dir;
        if (go_complete) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          rails <= go_next;
          start <= 1'b1;
        end
      end else if (rev_req) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int RAILS         = 4,
  parameter int SETTLE_FRAMES = 4,
  parameter int PHASE_TIMEOUT = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_req,
  input  logic             down_req,
  input  logic             vsync,
  output logic [RAILS-1:0] rail_en,
  output logic             busy,
  output logic             done
);
  logic wait_start;
  logic wait_fin;

  pps_step_ctrl #(
    .RAILS(RAILS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .up_req  (up_req),
    .down_req(down_req),
    .fin     (wait_fin),
    .rails   (rail_en),
    .busy    (busy),
    .done    (done),
    .start   (wait_start)
  );

  pps_frame_waiter #(
    .FRAMES (SETTLE_FRAMES),
    .TIMEOUT(PHASE_TIMEOUT)
  ) u_wait (
    .clk  (clk),
    .rst  (rst),
    .start(wait_start),
    .vsync(vsync),
    .fin  (wait_fin)
  );
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk #(
  parameter int RAILS         = 4,
  parameter int SETTLE_FRAMES = 4,
  parameter int PHASE_TIMEOUT = 10000
) (
  input logic             clk,
  input logic             rst,
  input logic [RAILS-1:0] rail_en,
  input logic             busy,
  input logic             done
);
  localparam logic [31:0] GAP_MAX = 32'(SETTLE_FRAMES * 2 * PHASE_TIMEOUT + 8);
  localparam logic [RAILS-1:0] ONE = RAILS'(1);

  logic [RAILS-1:0] prev_rails;
  logic [31:0]      gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rails <= '0;
      gap_cnt    <= '0;
    end else begin
      prev_rails <= rail_en;
      if (!busy || rail_en != prev_rails) gap_cnt <= '0;
      else                                gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R4: a step flips a single enable
  a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
    (rail_en != $past(rail_en)) |-> ($countones(rail_en ^ $past(rail_en)) == 1));

  // R2 / R3: enables always form a thermometer from the supply bit upward
  a_r2_order: assert property (@(posedge clk) disable iff (rst)
    ((rail_en & (rail_en + ONE)) == '0));

  // R7: enables move only while a sequence is running
  a_r7_change_busy: assert property (@(posedge clk) disable iff (rst)
    (rail_en != $past(rail_en)) |-> busy);

  // R7 / R8: completion only at a full or empty state and outside a sequence
  a_r7_done_end: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (rail_en == '0 || (&rail_en))));

  // R6: no settle wait exceeds two timed-out phases per frame
  a_r6_gap_bound: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= GAP_MAX);
endmodule

bind panel_pwr_seq panel_pwr_seq_chk #(
  .RAILS        (RAILS),
  .SETTLE_FRAMES(SETTLE_FRAMES),
  .PHASE_TIMEOUT(PHASE_TIMEOUT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rail_en(rail_en),
  .busy   (busy),
  .done   (done)
);

// File: tb/panel_pwr_seq_bench.sv
`timescale 1ns/1ps
module panel_pwr_seq_bench;
  localparam int RAILS = 4;
  localparam int S     = 2;
  localparam int T     = 16;
  localparam int LIMIT = 400;
  localparam int GAP_LO = S * T;
  localparam int GAP_HI = S * (T + 1) + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req = 1'b0;
  logic down_req = 1'b0;
  logic vsync = 1'b0;
  logic [RAILS-1:0] rail_en;
  logic busy;
  logic done;

  int n_tests = 0;
  int n_fail  = 0;
  int vmode   = 0;   // 0 toggling, 1 stuck low, 2 stuck high
  int vcnt    = 0;
  int rises   = 0;
  logic vs_q  = 1'b0;
  int rise_snap = 0;
  logic [RAILS-1:0] last_rails = '0;
  longint cycles = 0;

  always #4 clk = ~clk;

  panel_pwr_seq #(
    .RAILS(RAILS), .SETTLE_FRAMES(S), .PHASE_TIMEOUT(T)
  ) u_panel_pwr_seq (
    .clk(clk), .rst(rst), .up_req(up_req), .down_req(down_req),
    .vsync(vsync), .rail_en(rail_en), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    #2;
    if (vmode == 0) begin
      vcnt  = (vcnt + 1) % 10;
      vsync = (vcnt < 3);
    end else begin
      vsync = (vmode == 2);
    end
  end

  always @(posedge clk) begin
    if (vsync && !vs_q) rises <= rises + 1;
    vs_q <= vsync;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act=%0d exp=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [RAILS-1:0] therm(input int n);
    return RAILS'((1 << n) - 1);
  endfunction

  task automatic pulse(input bit u, input bit d);
    @(posedge clk); #2;
    up_req = u; down_req = d;
    @(posedge clk); #2;
    up_req = 1'b0; down_req = 1'b0;
  endtask

  // wait for the next enable change and check it
  task automatic wait_change(input logic [RAILS-1:0] exp, input bit chk_rise,
                             input bit chk_gap, input string tag);
    int cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (rail_en == last_rails && cyc < LIMIT);
    chk(rail_en == exp, tag, int'(rail_en), int'(exp));
    chk($countones(rail_en ^ last_rails) == 1, "R4 single bit per step",
        $countones(rail_en ^ last_rails), 1);
    chk(busy == 1'b1, "R7 busy during step", int'(busy), 1);
    if (chk_rise)
      chk(rises - rise_snap == S, "R5 vsync frames between steps", rises - rise_snap, S);
    if (chk_gap)
      chk(cyc >= GAP_LO && cyc <= GAP_HI, "R6 phase timeout gap", cyc, GAP_LO);
    rise_snap  = rises;
    last_rails = rail_en;
  endtask

  task automatic wait_done(input string tag);
    int cyc = 0;
    bit steady = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (rail_en != last_rails) steady = 1'b0;
    end while (!done && cyc < LIMIT);
    chk(done == 1'b1, tag, int'(done), 1);
    chk(steady, "R7 no change while finishing", int'(rail_en), int'(last_rails));
    @(negedge clk);
    chk(done == 1'b0, "R7 done is one cycle", int'(done), 0);
    chk(busy == 1'b0, "R7 busy low after done", int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(rail_en == '0, "R1 reset enables", int'(rail_en), 0);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);

    // R8: power-down while already off
    @(posedge clk); #2 down_req = 1'b1;
    @(posedge clk); #2 down_req = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R8 redundant down done", int'(done), 1);
    chk(rail_en == '0 && busy == 1'b0, "R8 redundant down no change", int'(rail_en), 0);

    // R2 full power-up, with a same-direction request ignored (R9)
    pulse(1'b1, 1'b0);
    wait_change(therm(1), 1'b0, 1'b0, "R2 supply first");
    pulse(1'b1, 1'b0);
    wait_change(therm(2), 1'b1, 1'b0, "R2 signals second");
    wait_change(therm(3), 1'b1, 1'b0, "R2 bias third");
    wait_change(therm(4), 1'b1, 1'b0, "R2 panel last");
    wait_done("R7 done after power-up");

    // R8: power-up while already on
    @(posedge clk); #2 up_req = 1'b1;
    @(posedge clk); #2 up_req = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R8 redundant up done", int'(done), 1);
    chk(rail_en == therm(4) && busy == 1'b0, "R8 redundant up no change", int'(rail_en), 15);

    // R3 full power-down
    pulse(1'b0, 1'b1);
    wait_change(therm(3), 1'b0, 1'b0, "R3 panel off first");
    wait_change(therm(2), 1'b1, 1'b0, "R3 bias off");
    wait_change(therm(1), 1'b1, 1'b0, "R3 signals off");
    wait_change(therm(0), 1'b1, 1'b0, "R3 supply off last");
    wait_done("R7 done after power-down");

    // R9 reversal sweep: turn around after k up-steps
    for (int k = 1; k <= RAILS; k++) begin
      pulse(1'b1, 1'b0);
      for (int i = 1; i <= k; i++)
        wait_change(therm(i), i > 1, 1'b0, "R9 up before reversal");
      pulse(1'b0, 1'b1);
      for (int j = k - 1; j >= 0; j--)
        wait_change(therm(j), 1'b1, 1'b0, "R9 down after reversal");
      wait_done("R9 done after reversal");
      chk(rail_en == '0, "R9 final off", int'(rail_en), 0);
    end

    // R10 both requests in idle: up wins
    pulse(1'b1, 1'b1);
    for (int i = 1; i <= RAILS; i++)
      wait_change(therm(i), i > 1, 1'b0, "R10 up priority");
    wait_done("R10 done");

    // R9 down-to-up reversal after two steps
    pulse(1'b0, 1'b1);
    wait_change(therm(3), 1'b0, 1'b0, "R9 down step");
    wait_change(therm(2), 1'b1, 1'b0, "R9 down step");
    pulse(1'b1, 1'b0);
    wait_change(therm(3), 1'b1, 1'b0, "R9 up after reversal");
    wait_change(therm(4), 1'b1, 1'b0, "R9 up after reversal");
    wait_done("R9 done after up reversal");

    // R6 vsync stuck low: down sequence must still complete
    vmode = 1;
    pulse(1'b0, 1'b1);
    wait_change(therm(3), 1'b0, 1'b0, "R6 stuck low step");
    for (int j = 2; j >= 0; j--)
      wait_change(therm(j), 1'b0, 1'b1, "R6 stuck low step");
    wait_done("R6 done with stuck low");

    // R6 vsync stuck high: up sequence must still complete
    vmode = 2;
    pulse(1'b1, 1'b0);
    wait_change(therm(1), 1'b0, 1'b0, "R6 stuck high step");
    for (int i = 2; i <= RAILS; i++)
      wait_change(therm(i), 1'b0, 1'b1, "R6 stuck high step");
    wait_done("R6 done with stuck high");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule